// File: doc/BRIEF.md
# ATM Transmit Cell Source with Idle Fill

This block feeds a byte-wide line with ATM cells. A transmit FIFO ahead of it holds complete user cells as 52 bytes each: 4 header bytes followed by 48 payload bytes. The FIFO shows its head byte and reports whether at least one whole cell is queued. On every cycle that the line accepts a byte, the block emits one byte of a 53-byte cell. The header error check byte is computed on the fly and placed after the header.

The block only chooses the kind of the next cell when the last byte of a cell goes out. If a whole user cell is waiting at that point, it is sent next. Otherwise the standard idle cell is sent and a sticky underrun event is raised. Software clears the event by writing a one to it. A mode input decides whether the event also drives the interrupt line.

Top module: `atm_tx_cell_src`

## Requirements
- R1: While reset is applied and on the first cycle after it, tx_valid_o, ev_urun_o and irq_o are 0. The first cell after reset is an idle cell.
- R2: Each cycle with line_en_i high emits exactly one byte, visible on the next cycle with tx_valid_o high. A cycle with line_en_i low gives tx_valid_o low on the next cycle. A cell is 53 bytes long: 4 header bytes, then the check byte, then 48 payload bytes. tx_sop_o marks the first header byte.
- R3: The check byte is computed over the 4 header bytes, first byte first and MSB first. It is the CRC-8 remainder with generator x^8+x^2+x+1 and a zero start value, XORed with 0x55.
- R4: An idle cell has the header bytes 0x00,0x00,0x00,0x01 in that order, the check byte 0x52, and all payload bytes 0x6A. tx_idle_o is high on every byte of an idle cell.
- R5: The kind of the next cell is taken from cell_avail_i in the cycle that emits the last byte of the current cell. A cell that becomes available part-way through a cell waits for the next boundary.
- R6: fifo_pop_o is high exactly in the line_en_i cycles that emit a header or payload byte of a user cell. Those bytes are taken from fifo_data_i in that same cycle. That makes 52 pops per user cell, and none on the check byte.
- R7: If cell_avail_i is low in the cycle that emits the last byte of any cell, ev_urun_o becomes 1 on the next cycle. It then stays 1 until it is cleared.
- R8: A cycle with ev_clr_wr_i high and ev_clr_data_i high clears ev_urun_o from the next cycle on. If ev_clr_data_i is low, the write has no effect.
- R9: If a clear and a new underrun fall in the same cycle, the underrun wins and ev_urun_o stays 1.
- R10: irq_o equals ev_urun_o AND urun_en_i. The event bit is updated the same way whatever the state of urun_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_en_i | input | 1 | The line takes one byte this cycle |
| cell_avail_i | input | 1 | At least one complete cell is in the FIFO |
| fifo_data_i | input | 8 | FIFO head byte |
| fifo_pop_o | output | 1 | Removes the head byte from the FIFO |
| tx_byte_o | output | 8 | Cell byte sent to the line |
| tx_valid_o | output | 1 | tx_byte_o holds a byte |
| tx_sop_o | output | 1 | First byte of a cell |
| tx_idle_o | output | 1 | The byte belongs to an idle cell |
| urun_en_i | input | 1 | Lets the underrun event drive the interrupt |
| ev_clr_wr_i | input | 1 | Write strobe for the event register |
| ev_clr_data_i | input | 1 | Write data; a 1 clears the underrun bit |
| ev_urun_o | output | 1 | Sticky underrun event |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land in the same cycle: a software clear of the event, and a new underrun raised by the last byte of a cell going out with no cell queued. The bench provokes this over a long idle stretch. It times the write-one-to-clear pulse from its model's byte position so that the pulse lands exactly on byte 53, and checks that the event bit is still set afterwards. Clears placed on other cycles, and writes carrying a zero, are compared against the same model. That model tracks position, cell kind and event state every clock.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam int unsigned HDR_BYTES = 4;
  localparam int unsigned PAY_BYTES = 48;
  localparam logic [7:0]  HEC_POLY  = 8'h07;
  localparam logic [7:0]  HEC_COSET = 8'h55;
  localparam logic [7:0]  IDLE_PAY  = 8'h6A;
  localparam logic [8*HDR_BYTES-1:0] IDLE_HDR = 32'h0000_0001;

  function automatic logic [7:0] crc8_byte(logic [7:0] crc, logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int b = 0; b < 8; b++)
      c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/atm_hec_acc.sv
module atm_hec_acc
  import atm_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       first_i,
  input  logic [7:0] byte_i,
  output logic [7:0] hec_o
);
  logic [7:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '0;
    else if (en_i) crc_q <= crc8_byte(first_i ? 8'h00 : crc_q, byte_i);
  end

  assign hec_o = crc_q ^ HEC_COSET;
endmodule

// File: rtl/atm_cell_seq.sv
module atm_cell_seq #(
  parameter int unsigned CELL_BYTES = 53,
  localparam int unsigned IDX_W = $clog2(CELL_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             avail_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             user_o,
  output logic             boundary_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic             user_q;

  assign boundary_o = step_i && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      user_q <= 1'b0;
    end else if (boundary_o) begin
      idx_q  <= '0;
      user_q <= avail_i;
    end else if (step_i) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign user_o = user_q;
endmodule

// File: rtl/atm_urun_ev.sv
module atm_urun_ev (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic ev_o
);
  logic ev_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= 1'b0;
    else         ev_q <= set_i | (ev_q & ~clr_i);
  end

  assign ev_o = ev_q;
endmodule

// File: rtl/atm_tx_cell_src.sv
module atm_tx_cell_src
  import atm_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_en_i,
  input  logic       cell_avail_i,
  input  logic [7:0] fifo_data_i,
  output logic       fifo_pop_o,
  output logic [7:0] tx_byte_o,
  output logic       tx_valid_o,
  output logic       tx_sop_o,
  output logic       tx_idle_o,
  input  logic       urun_en_i,
  input  logic       ev_clr_wr_i,
  input  logic       ev_clr_data_i,
  output logic       ev_urun_o,
  output logic       irq_o
);
  localparam int unsigned CELL_BYTES = HDR_BYTES + 1 + PAY_BYTES;
  localparam int unsigned IDX_W      = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] HEC_IDX = IDX_W'(HDR_BYTES);

  logic [IDX_W-1:0] idx;
  logic             user, boundary;
  logic             in_hdr, in_hec;
  logic [7:0]       hec, idle_hdr_byte, cur_byte;

  atm_cell_seq #(.CELL_BYTES(CELL_BYTES)) u_seq (
    .clk_i, .rst_ni,
    .step_i     (line_en_i),
    .avail_i    (cell_avail_i),
    .idx_o      (idx),
    .user_o     (user),
    .boundary_o (boundary)
  );

  assign in_hdr = idx < HEC_IDX;
  assign in_hec = idx == HEC_IDX;

  always_comb begin
    idle_hdr_byte = '0;
    for (int k = 0; k < HDR_BYTES; k++)
      if (idx == IDX_W'(k)) idle_hdr_byte = IDLE_HDR[8*(HDR_BYTES-1-k) +: 8];
  end

  always_comb begin
    if (in_hdr)      cur_byte = user ? fifo_data_i : idle_hdr_byte;
    else if (in_hec) cur_byte = hec;
    else             cur_byte = user ? fifo_data_i : IDLE_PAY;
  end

  atm_hec_acc u_hec (
    .clk_i, .rst_ni,
    .en_i    (line_en_i && in_hdr),
    .first_i (idx == '0),
    .byte_i  (cur_byte),
    .hec_o   (hec)
  );

  atm_urun_ev u_ev (
    .clk_i, .rst_ni,
    .set_i (boundary && !cell_avail_i),
    .clr_i (ev_clr_wr_i && ev_clr_data_i),
    .ev_o  (ev_urun_o)
  );

  assign fifo_pop_o = line_en_i && user && !in_hec;
  assign irq_o      = ev_urun_o && urun_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_byte_o  <= '0;
      tx_sop_o   <= 1'b0;
      tx_idle_o  <= 1'b0;
    end else begin
      tx_valid_o <= line_en_i;
      if (line_en_i) begin
        tx_byte_o <= cur_byte;
        tx_sop_o  <= idx == '0;
        tx_idle_o <= !user;
      end
    end
  end
endmodule

// File: rtl/atm_tx_cell_src_chk.sv
module atm_tx_cell_src_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_en_i,
  input logic       fifo_pop_o,
  input logic [7:0] tx_byte_o,
  input logic       tx_valid_o,
  input logic       tx_sop_o,
  input logic       tx_idle_o,
  input logic       ev_urun_o,
  input logic       ev_clr_wr_i,
  input logic       ev_clr_data_i
);
  p_valid_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_en_i |=> tx_valid_o);
  p_no_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_en_i |=> !tx_valid_o);
  p_pop_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> line_en_i);
  p_idle_sop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_sop_o && tx_idle_o) |-> tx_byte_o == 8'h00);
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_urun_o && !(ev_clr_wr_i && ev_clr_data_i)) |=> ev_urun_o);
  p_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ev_urun_o) |-> $past(line_en_i));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_clr_wr_i && ev_clr_data_i && !line_en_i) |=> !ev_urun_o);
endmodule

bind atm_tx_cell_src atm_tx_cell_src_chk u_chk (.*);

// File: tb/sim_atm_tx_cell_src.sv
`timescale 1ns/1ps
module sim_atm_tx_cell_src;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_en_i = 1'b0, cell_avail_i = 1'b0;
  logic [7:0] fifo_data_i = '0;
  logic       fifo_pop_o, tx_valid_o, tx_sop_o, tx_idle_o;
  logic [7:0] tx_byte_o;
  logic       urun_en_i = 1'b0, ev_clr_wr_i = 1'b0, ev_clr_data_i = 1'b0;
  logic       ev_urun_o, irq_o;

  always #2 clk_i = ~clk_i;

  atm_tx_cell_src u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] hec_ref(logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0] ^ 8'h55;
  endfunction

  logic [7:0] q[$];
  int unsigned seed = 1;

  task automatic push_cell();
    for (int k = 0; k < 52; k++) q.push_back(8'((seed * 37 + k * 11) ^ (k << 3)));
    seed++;
  endtask

  // reference model state
  int midx = 0;
  bit muser = 0, mev = 0, first_cell = 1;
  logic [31:0] mhdr;
  bit exp_valid = 0, exp_sop = 0, exp_idle = 0, exp_ev = 0;
  logic [7:0] exp_byte = '0;
  string exp_tag = "R2";
  string ev_tag = "R7";
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1 valid", tx_valid_o, 0);
    chk("R1 ev", ev_urun_o, 0);
    chk("R1 irq", irq_o, 0);
    rst_ni = 1'b1;
    for (int n = 0; n < 2600; n++) begin
      bit le, clr_w, clr_d, avail, pop, set_ev;
      @(negedge clk_i);
      chk("R2 valid", tx_valid_o, exp_valid);
      if (exp_valid) begin
        chk(exp_tag, tx_byte_o, exp_byte);
        chk("R2 sop", tx_sop_o, exp_sop);
        chk(first_cell ? "R1 idle" : "R5 kind", tx_idle_o, exp_idle);
      end
      chk(ev_tag, ev_urun_o, exp_ev);

      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      le = 1; clr_w = 0; clr_d = 0;
      urun_en_i = (n < 150) || (n >= 1000);
      if (n == 60)  begin clr_w = 1; clr_d = 0; end // R8 zero write
      if (n == 100) begin clr_w = 1; clr_d = 1; end // R8 clear
      if (n >= 300 && n < 1500) begin
        le = lfsr[1:0] != 2'b00;
        if (q.size() < 104) push_cell();
      end
      if (n == 1700) push_cell();                   // R5 arrives mid idle cell
      if (n >= 2000 && n < 2500 && midx == 52) begin clr_w = 1; clr_d = 1; end // R9
      if (n >= 2500) begin
        le = 0;
        if (n == 2550) begin clr_w = 1; clr_d = 1; end
      end
      avail = q.size() >= 52;
      line_en_i = le; cell_avail_i = avail;
      ev_clr_wr_i = clr_w; ev_clr_data_i = clr_d;
      fifo_data_i = (q.size() > 0) ? q[0] : 8'h00;
      #1;
      chk("R10 irq", irq_o, int'(mev && urun_en_i));
      pop = le && muser && midx != 4;
      chk("R6 pop", fifo_pop_o, pop);

      exp_valid = le;
      set_ev = 0;
      if (le) begin
        if (midx == 0) first_cell = first_cell && (n < 53);
        exp_sop = midx == 0;
        exp_idle = !muser;
        if (midx < 4) begin
          exp_byte = muser ? q[0] : ((midx == 3) ? 8'h01 : 8'h00);
          mhdr[8*(3-midx) +: 8] = exp_byte;
          exp_tag = muser ? "R6 header" : "R4 idle header";
        end else if (midx == 4) begin
          exp_byte = hec_ref(mhdr);
          exp_tag = muser ? "R3 hec" : "R4 idle hec";
          if (!muser && exp_byte != 8'h52) begin
            checks++; errors++;
            $display("FAIL R4 model hec actual=%0h expected=52", exp_byte);
          end
        end else begin
          exp_byte = muser ? q[0] : 8'h6A;
          exp_tag = muser ? "R6 payload" : "R4 idle payload";
        end
        if (pop) void'(q.pop_front());
        if (midx == 52) begin
          set_ev = !avail;
          muser = avail;
          midx = 0;
        end else midx++;
      end
      ev_tag = (set_ev && clr_w && clr_d) ? "R9 set wins" :
               (clr_w && !clr_d && mev) ? "R8 zero write" :
               (clr_w && clr_d) ? "R8 clear" : "R7 sticky";
      mev = set_ev || (mev && !(clr_w && clr_d));
      exp_ev = mev;
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule